// File: doc/BRIEF.md
# Attention Interrupt Mask Controller

This block owns the single level-style interrupt that a management controller raises toward its host. It keeps two mask bits, an enable and a pending flag, alongside three status flags: a response-attention flag, a system-software attention flag and a controller-busy flag. The host writes the mask, acknowledges attention flags and posts requests. The controller side signals that a response is ready and asks for the software attention flag to be set or cleared. A cold reset pulse drops the interrupt state without touching the attention flags.

The pending bit does two jobs. It records that an interrupt was raised, and writing 1 to it acknowledges that interrupt. Whether a new interrupt is raised depends on the edge of the enable bit, on which attention source is active, and on whether pending is already set. The output line is a registered level that follows raise and lower events. A raise reaches the pin only while the global interrupt-use input is high. Line polarity and the mask bit positions are parameters.

Top module: `atn_irq_ctrl`

## Requirements
- R1: After reset the line is inactive and enable, pending, response attention, software attention and busy are all 0. The mask read bus shows enable at bit 0 and pending at bit 1.
- R2: A mask write whose bit 0 is 1 while enable is 0 sets enable. If either attention flag is set, it also sets pending and raises the line.
- R3: A mask write whose bit 0 is 0 while enable is 1 clears enable. It also clears pending and lowers the line if pending was set.
- R4: A mask write with bit 1 equal to 1 while pending is set clears pending and lowers the line. This is checked after any enable change in the same write.
- R5: A response-ready pulse clears busy and sets response attention. It sets pending and raises the line only when pending was 0 and enable is 1.
- R6: A software-attention request whose value equals the current flag changes nothing.
- R7: A request that sets software attention raises pending and the line only when it carries its interrupt flag, response attention is clear and enable is 1.
- R8: A request that clears software attention while response attention is clear drops a set pending bit and lowers the line. While response attention is set, pending is kept.
- R9: Cold reset clears enable and pending and lowers the line. It leaves the attention flags unchanged.
- R10: A raise drives the line active only if the global interrupt-use input is high in that cycle. Pending is set either way, and the line is not raised later by itself.
- R11: The line holds its level until a raise or lower event occurs.
- R12: A host request pulse sets busy. Host acknowledge pulses clear response or software attention and leave pending and the line unchanged.
- R13: Events in one cycle are applied in this order: mask write, then response ready, then software request. Cold reset overrides all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr_i | input | 1 | Host mask write strobe |
| mask_wdata_i | input | MASK_W | Host mask write data |
| mask_rd_o | output | MASK_W | Mask read value (enable, pending) |
| host_req_i | input | 1 | Host request pulse, sets busy |
| ack_rsp_i | input | 1 | Host clears response attention |
| ack_sw_i | input | 1 | Host clears software attention |
| rsp_rdy_i | input | 1 | Controller response-ready pulse |
| sw_req_i | input | 1 | Controller software-attention request |
| sw_val_i | input | 1 | Requested software-attention value |
| sw_irq_i | input | 1 | Request may raise an interrupt |
| cold_rst_i | input | 1 | Cold reset pulse for interrupt state |
| irq_use_i | input | 1 | Global interrupt-use enable |
| rsp_atn_o | output | 1 | Response attention flag |
| sw_atn_o | output | 1 | Software attention flag |
| busy_o | output | 1 | Controller busy flag |
| irq_o | output | 1 | Interrupt line |

## Verification
On every cycle, assertions check that cold reset empties the mask, that disabling or acknowledging drops pending, that an enabled response sets pending, and that a matching software request leaves state alone. They also check that the line stays steady without an event, never rises unless the global input was high, and is never active without pending. Only the bench scenarios can show whole sequences: which attention source blocks a software raise, that pending set with the global input low does not later assert the line, and the results when several events land in the same cycle.

// File: rtl/atn_irq_pkg.sv
package atn_irq_pkg;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_RAISE = 2'd1,
      ACT_LOWER = 2'd2
   } line_act_e;

   typedef struct packed {
      logic en;
      logic pend;
   } mask_t;

   typedef struct packed {
      logic rsp;
      logic sw;
      logic busy;
   } flags_t;

endpackage

// File: rtl/atn_flags.sv
module atn_flags
   import atn_irq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   host_req_i,
   input  logic   ack_rsp_i,
   input  logic   ack_sw_i,
   input  logic   rsp_rdy_i,
   input  logic   sw_req_i,
   input  logic   sw_val_i,
   output flags_t flags_o,
   output logic   sw_chg_o
);

   flags_t flg_q;
   flags_t flg_d;

   assign sw_chg_o = sw_req_i && (sw_val_i != flg_q.sw);

   always_comb begin
      flg_d = flg_q;
      if (ack_rsp_i) flg_d.rsp = 1'b0;
      if (ack_sw_i)  flg_d.sw  = 1'b0;
      if (host_req_i) flg_d.busy = 1'b1;
      if (rsp_rdy_i) begin
         flg_d.busy = 1'b0;
         flg_d.rsp  = 1'b1;
      end
      if (sw_chg_o) flg_d.sw = sw_val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= flg_d;
   end

   assign flags_o = flg_q;

   // R5: response ready always leaves busy clear and response attention set
   p_rsp_sets_atn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rdy_i |=> (flg_q.rsp && !flg_q.busy));

   // R6: a matching software request leaves the flag alone
   p_sw_match_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req_i && (sw_val_i == flg_q.sw) && !ack_sw_i) |=> $stable(flg_q.sw));

endmodule

// File: rtl/atn_irq_mask.sv
module atn_irq_mask
   import atn_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_i,
   input  logic      wr_en_bit_i,
   input  logic      wr_pend_bit_i,
   input  logic      rsp_atn_i,
   input  logic      sw_atn_i,
   input  logic      rsp_rdy_i,
   input  logic      sw_chg_i,
   input  logic      sw_val_i,
   input  logic      sw_irq_i,
   input  logic      cold_i,
   output mask_t     mask_o,
   output line_act_e act_o
);

   mask_t     msk_q;
   mask_t     msk_d;
   line_act_e act_d;
   logic      rsp_eff;

   assign rsp_eff = rsp_atn_i || rsp_rdy_i;

   always_comb begin
      msk_d = msk_q;
      act_d = ACT_NONE;
      // step 1: host mask write
      if (wr_i) begin
         if (wr_en_bit_i && !msk_d.en) begin
            if (rsp_atn_i || sw_atn_i) begin
               msk_d.pend = 1'b1;
               act_d      = ACT_RAISE;
            end
            msk_d.en = 1'b1;
         end else if (!wr_en_bit_i && msk_d.en) begin
            if (msk_d.pend) begin
               msk_d.pend = 1'b0;
               act_d      = ACT_LOWER;
            end
            msk_d.en = 1'b0;
         end
         if (wr_pend_bit_i && msk_d.pend) begin
            msk_d.pend = 1'b0;
            act_d      = ACT_LOWER;
         end
      end
      // step 2: response ready
      if (rsp_rdy_i && !msk_d.pend && msk_d.en) begin
         msk_d.pend = 1'b1;
         act_d      = ACT_RAISE;
      end
      // step 3: software attention change
      if (sw_chg_i) begin
         if (sw_val_i) begin
            if (sw_irq_i && !rsp_eff && msk_d.en) begin
               msk_d.pend = 1'b1;
               act_d      = ACT_RAISE;
            end
         end else if (!rsp_eff && msk_d.pend) begin
            msk_d.pend = 1'b0;
            act_d      = ACT_LOWER;
         end
      end
      // cold reset dominates
      if (cold_i) begin
         msk_d = '0;
         act_d = ACT_LOWER;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk_q <= '0;
      else        msk_q <= msk_d;
   end

   assign mask_o = msk_q;
   assign act_o  = act_d;

   // R9: cold reset empties the mask
   p_cold_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cold_i |=> (!msk_q.en && !msk_q.pend));

   // R3: turning the enable off leaves nothing pending
   p_disable_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && msk_q.en && !wr_en_bit_i) |=> (!msk_q.pend && !msk_q.en));

   // R4: acknowledging pending clears it unless a later step re-raises
   p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wr_pend_bit_i && !rsp_rdy_i && !(sw_chg_i && sw_val_i)) |=> !msk_q.pend);

   // R5: an enabled response leaves pending set
   p_rsp_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_rdy_i && msk_q.en && !wr_i && !cold_i) |=> msk_q.pend);

   // R2: pending can only appear while enabled
   p_pend_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      msk_q.pend |-> msk_q.en);

endmodule

// File: rtl/atn_irq_line.sv
module atn_irq_line
   import atn_irq_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_act_e act_i,
   input  logic      irq_use_i,
   output logic      line_o,
   output logic      pin_o
);

   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
      end else begin
         unique case (act_i)
            ACT_LOWER: line_q <= 1'b0;
            ACT_RAISE: if (irq_use_i) line_q <= 1'b1;
            default:   line_q <= line_q;
         endcase
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pin_o = ~line_q;
      end else begin : g_high
         assign pin_o = line_q;
      end
   endgenerate

   assign line_o = line_q;

   // R11: without an event the line keeps its level
   p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_NONE) |=> $stable(line_q));

   // R10: the line only rises after a cycle with the global input high
   p_line_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_q) |-> $past(irq_use_i));

endmodule

// File: rtl/atn_irq_ctrl.sv
module atn_irq_ctrl
   import atn_irq_pkg::*;
#(
   parameter int MASK_W     = 8,
   parameter int EN_BIT     = 0,
   parameter int PEND_BIT   = 1,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_wr_i,
   input  logic [MASK_W-1:0] mask_wdata_i,
   output logic [MASK_W-1:0] mask_rd_o,
   input  logic              host_req_i,
   input  logic              ack_rsp_i,
   input  logic              ack_sw_i,
   input  logic              rsp_rdy_i,
   input  logic              sw_req_i,
   input  logic              sw_val_i,
   input  logic              sw_irq_i,
   input  logic              cold_rst_i,
   input  logic              irq_use_i,
   output logic              rsp_atn_o,
   output logic              sw_atn_o,
   output logic              busy_o,
   output logic              irq_o
);

   localparam int TOP_BIT = (EN_BIT > PEND_BIT) ? EN_BIT : PEND_BIT;

   initial begin
      a_bits_differ: assert (EN_BIT != PEND_BIT)
         else $error("enable and pending share a bit");
      a_bits_fit: assert (TOP_BIT < MASK_W && EN_BIT >= 0 && PEND_BIT >= 0)
         else $error("mask bits outside data width");
   end

   flags_t    flags;
   logic      sw_chg;
   mask_t     msk;
   line_act_e act;
   logic      line;
   logic      unused_wdata;

   assign unused_wdata = ^mask_wdata_i;

   atn_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_req_i (host_req_i),
      .ack_rsp_i  (ack_rsp_i),
      .ack_sw_i   (ack_sw_i),
      .rsp_rdy_i  (rsp_rdy_i),
      .sw_req_i   (sw_req_i),
      .sw_val_i   (sw_val_i),
      .flags_o    (flags),
      .sw_chg_o   (sw_chg)
   );

   atn_irq_mask u_mask (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_i          (mask_wr_i),
      .wr_en_bit_i   (mask_wdata_i[EN_BIT]),
      .wr_pend_bit_i (mask_wdata_i[PEND_BIT]),
      .rsp_atn_i     (flags.rsp),
      .sw_atn_i      (flags.sw),
      .rsp_rdy_i     (rsp_rdy_i),
      .sw_chg_i      (sw_chg),
      .sw_val_i      (sw_val_i),
      .sw_irq_i      (sw_irq_i),
      .cold_i        (cold_rst_i),
      .mask_o        (msk),
      .act_o         (act)
   );

   atn_irq_line #(.ACTIVE_LOW(ACTIVE_LOW)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act),
      .irq_use_i (irq_use_i),
      .line_o    (line),
      .pin_o     (irq_o)
   );

   generate
      for (genvar b = 0; b < MASK_W; b++) begin : g_rd
         if (b == EN_BIT) begin : g_en
            assign mask_rd_o[b] = msk.en;
         end else if (b == PEND_BIT) begin : g_pend
            assign mask_rd_o[b] = msk.pend;
         end else begin : g_zero
            assign mask_rd_o[b] = 1'b0;
         end
      end
   endgenerate

   assign rsp_atn_o = flags.rsp;
   assign sw_atn_o  = flags.sw;
   assign busy_o    = flags.busy;

   // R11: an active line always has its pending bit behind it
   p_line_needs_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      line |-> msk.pend);

   // R6: a matching software request alone does not move pending
   p_sw_match_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req_i && (sw_val_i == flags.sw) && !mask_wr_i && !rsp_rdy_i && !cold_rst_i)
      |=> $stable(msk.pend));

   // R12: host acknowledges alone leave pending untouched
   p_ack_keeps_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_rsp_i || ack_sw_i) && !mask_wr_i && !rsp_rdy_i && !sw_req_i && !cold_rst_i)
      |=> $stable(msk.pend));

endmodule

// File: tb/tb_atn_irq_ctrl.sv
module tb_atn_irq_ctrl;

   localparam int MASK_W = 8;
   localparam int NVEC   = 29;

   // vector: wr, wd[1:0], rsp, sreq, sval, sirq, ack_rsp, ack_sw, hreq, cold, use, spare
   //         | expected: irq, en, pend, rsp_atn, sw_atn, busy
   localparam logic [18:0] VEC [NVEC] = '{
      19'b0_00_0_0_0_0_0_0_0_0_1_0_000000,
      19'b0_00_0_0_0_0_0_0_1_0_1_0_000001,
      19'b0_00_1_0_0_0_0_0_0_0_1_0_000100,
      19'b1_01_0_0_0_0_0_0_0_0_1_0_111100,
      19'b0_00_0_0_0_0_0_0_0_0_1_0_111100,
      19'b1_11_0_0_0_0_0_0_0_0_1_0_010100,
      19'b0_00_1_0_0_0_0_0_0_0_1_0_111100,
      19'b0_00_0_0_0_0_1_0_0_0_1_0_111000,
      19'b0_00_0_1_1_1_0_0_0_0_1_0_111010,
      19'b0_00_0_1_1_1_0_0_0_0_1_0_111010,
      19'b0_00_0_1_0_0_0_0_0_0_1_0_010000,
      19'b0_00_0_1_1_0_0_0_0_0_1_0_010010,
      19'b1_00_0_0_0_0_0_0_0_0_1_0_000010,
      19'b1_01_0_0_0_0_0_0_0_0_1_0_111010,
      19'b1_00_0_0_0_0_0_0_0_0_1_0_000010,
      19'b1_01_0_0_0_0_0_0_0_0_0_0_011010,
      19'b0_00_0_0_0_0_0_0_0_0_1_0_011010,
      19'b1_11_0_0_0_0_0_0_0_0_1_0_010010,
      19'b0_00_0_0_0_0_0_1_0_0_1_0_010000,
      19'b0_00_1_0_0_0_0_0_0_0_1_0_111100,
      19'b1_11_0_0_0_0_0_0_0_0_1_0_010100,
      19'b0_00_0_1_1_1_0_0_0_0_1_0_010110,
      19'b0_00_1_0_0_0_0_0_0_0_1_0_111110,
      19'b0_00_0_1_0_0_0_0_0_0_1_0_111100,
      19'b0_00_0_0_0_0_0_0_0_1_1_0_000100,
      19'b1_01_0_0_0_0_0_0_0_1_1_0_000100,
      19'b1_11_1_0_0_0_0_0_0_0_1_0_111100,
      19'b0_00_0_0_0_0_1_0_0_0_1_0_111000,
      19'b0_00_0_1_0_0_0_0_0_0_1_0_111000
   };

   function automatic string vec_tag(input int i);
      case (i)
         0:              return "R1";
         1, 7, 18, 27:   return "R12";
         2, 6, 19, 22:   return "R5";
         3, 13:          return "R2";
         4:              return "R11";
         5, 17, 20:      return "R4";
         8, 11, 21:      return "R7";
         9, 28:          return "R6";
         10, 23:         return "R8";
         12, 14:         return "R3";
         15, 16:         return "R10";
         24:             return "R9";
         default:        return "R13";
      endcase
   endfunction

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mask_wr_i = 1'b0;
   logic [MASK_W-1:0] mask_wdata_i = '0;
   logic [MASK_W-1:0] mask_rd_o;
   logic              host_req_i = 1'b0;
   logic              ack_rsp_i = 1'b0;
   logic              ack_sw_i = 1'b0;
   logic              rsp_rdy_i = 1'b0;
   logic              sw_req_i = 1'b0;
   logic              sw_val_i = 1'b0;
   logic              sw_irq_i = 1'b0;
   logic              cold_rst_i = 1'b0;
   logic              irq_use_i = 1'b1;
   logic              rsp_atn_o;
   logic              sw_atn_o;
   logic              busy_o;
   logic              irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   atn_irq_ctrl #(.MASK_W(MASK_W)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .mask_rd_o    (mask_rd_o),
      .host_req_i   (host_req_i),
      .ack_rsp_i    (ack_rsp_i),
      .ack_sw_i     (ack_sw_i),
      .rsp_rdy_i    (rsp_rdy_i),
      .sw_req_i     (sw_req_i),
      .sw_val_i     (sw_val_i),
      .sw_irq_i     (sw_irq_i),
      .cold_rst_i   (cold_rst_i),
      .irq_use_i    (irq_use_i),
      .rsp_atn_o    (rsp_atn_o),
      .sw_atn_o     (sw_atn_o),
      .busy_o       (busy_o),
      .irq_o        (irq_o)
   );

   function automatic logic [5:0] observed();
      return {irq_o, mask_rd_o[0], mask_rd_o[1], rsp_atn_o, sw_atn_o, busy_o};
   endfunction

   task automatic check6(input string tag, input logic [5:0] exp);
      logic [5:0] act;
      act = observed();
      checks++;
      if (act !== exp || mask_rd_o[MASK_W-1:2] !== '0) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b (irq,en,pend,rsp,sw,busy) upper=%b",
                  tag, act, exp, mask_rd_o[MASK_W-1:2]);
      end
   endtask

   task automatic drive(input logic [18:0] v);
      mask_wr_i    = v[18];
      mask_wdata_i = {{(MASK_W-2){1'b0}}, v[17:16]};
      rsp_rdy_i    = v[15];
      sw_req_i     = v[14];
      sw_val_i     = v[13];
      sw_irq_i     = v[12];
      ack_rsp_i    = v[11];
      ack_sw_i     = v[10];
      host_req_i   = v[9];
      cold_rst_i   = v[8];
      irq_use_i    = v[7];
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check6("R1", 6'b000000);
      rst_n = 1'b1;
      @(negedge clk);
      check6("R1", 6'b000000);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i]);
         @(posedge clk);
         @(negedge clk);
         check6(vec_tag(i), VEC[i][5:0]);
      end
      drive(19'b0_00_0_0_0_0_0_0_0_0_1_0_000000);

      // R11: level held over idle cycles
      repeat (4) @(negedge clk);
      check6("R11", 6'b111000);

      // R1: reset during operation returns everything to zero
      rst_n = 1'b0;
      @(negedge clk);
      check6("R1", 6'b000000);
      rst_n = 1'b1;
      @(negedge clk);
      check6("R1", 6'b000000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule